// File: doc/BRIEF.md
# Edge-Triggered Two-Level Interrupt Aggregator

This block gathers interrupt causes raised by a secure co-processor and presents a single interrupt line to a host processor. It has two levels. The lower level holds eight cause bits. Each cause bit has its own enable bit. Only causes 0, 1 and 2 are implemented; the other five positions are reserved. The upper level has two sources. Source 0 is the secure side, which summarises the lower level. Source 1 is the bridge side, fed by a mailbox event strobe. The upper level has its own pending, enable and mask registers.

The lower level is edge-sensitive. A cause feeds the upper level only at the moment its status-and-enable condition becomes true. A condition that stays true after software has acknowledged the upper level does not raise the interrupt again. The secure-side pending flag is sticky, so a condition that holds for only one cycle is never lost. Software reaches all registers through a plain 32-bit write/read port, and acknowledges a flag by writing one to it.

Top module: `hier_irq_agg`

## Requirements
- R1: After reset, every register reads zero and `host_irq` is low.
- R2: A strobe on `cause_set[i]` for i in 0..2 sets cause status bit i at the next clock edge. Status bits 3..7 ignore both strobes and writes, and always read zero.
- R3: In cause status (offset 0x00), writing 1 to a bit clears it and writing 0 leaves it unchanged. When a strobe and a clear hit the same bit in the same cycle, the bit stays set.
- R4: Cause enable (offset 0x04) is read/write for bits 0..2 only. Bits 3..7 read zero.
- R5: Top status bit 0 (secure side) becomes set one clock after some cause's (status AND enable) changes from 0 to 1. If that condition only stays at 1, the bit is not set again after software clears it.
- R6: Setting an enable bit while the matching status bit is already 1 counts as a 0-to-1 change of the condition, so it sets top status bit 0.
- R7: Top status bit 1 (bridge side) is set at the clock edge where `mbox_evt` is high. Writing 1 to bit 1 at offset 0x08 clears it. When the strobe and the clear arrive in the same cycle, the bit stays set.
- R8: Top status (offset 0x08) shows both pending flags before the enable and mask are applied.
- R9: `host_irq` is high exactly when some source k (0 = secure, 1 = bridge) is pending, has top-enable bit k = 1 (offset 0x0C), and has top-mask bit k = 0 (offset 0x10). It follows register changes in the same cycle.
- R10: Reads from any address other than 0x00, 0x04, 0x08, 0x0C and 0x10 return zero. Writes to those other addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_set | input | NUM_CAUSES | One-cycle set strobes, one per cause |
| mbox_evt | input | 1 | One-cycle strobe from the mailbox (bridge) source |
| reg_wr | input | 1 | Write enable of the register port |
| reg_addr | input | ADDR_W | Byte address of the register port |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`; combinational |
| host_irq | output | 1 | Aggregated interrupt to the host |

## Verification
On every cycle, the assertions check four things:
- A strobed cause lands in its status bit.
- The secure flag only rises after a condition edge in the lower level.
- The bridge flag follows its strobe and its write-one-to-clear, with the strobe winning a tie.
- `host_irq` stays low when nothing is pending or everything is masked.

Some behaviours only the bench scenarios can show. One is that a condition held high does not re-trigger after an acknowledge. Another is that enabling an already-set cause counts as an edge. The rest are the exact cycle of each flag rise, the readback of reserved bits, and the silence of unmapped addresses.

// File: rtl/hier_irq_pkg.sv
package hier_irq_pkg;

   // Register byte offsets
   localparam int OFF_CAUSE_STAT = 'h00;
   localparam int OFF_CAUSE_EN   = 'h04;
   localparam int OFF_TOP_STAT   = 'h08;
   localparam int OFF_TOP_EN     = 'h0C;
   localparam int OFF_TOP_MASK   = 'h10;

   // Upper-level source positions
   localparam int SRC_SEC = 0;
   localparam int SRC_BRG = 1;
   localparam int NUM_SRC = 2;

   typedef struct packed {
      logic cause_stat;
      logic cause_en;
      logic top_stat;
      logic top_en;
      logic top_mask;
   } reg_sel_t;

endpackage

// File: rtl/hier_irq_reg_decode.sv
module hier_irq_reg_decode
   import hier_irq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_t          hit_o
);

   always_comb begin
      hit_o            = '0;
      hit_o.cause_stat = (addr_i == ADDR_W'(OFF_CAUSE_STAT));
      hit_o.cause_en   = (addr_i == ADDR_W'(OFF_CAUSE_EN));
      hit_o.top_stat   = (addr_i == ADDR_W'(OFF_TOP_STAT));
      hit_o.top_en     = (addr_i == ADDR_W'(OFF_TOP_EN));
      hit_o.top_mask   = (addr_i == ADDR_W'(OFF_TOP_MASK));
   end

endmodule

// File: rtl/hier_irq_cause_bank.sv
module hier_irq_cause_bank #(
   parameter int             N    = 8,
   parameter logic [N-1:0]   USED = 8'h07
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         wr_stat_i,
   input  logic         wr_en_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] stat_o,
   output logic [N-1:0] en_o,
   output logic [N-1:0] rise_o
);

   logic [N-1:0] stat_q, en_q, cond_prev_q;
   logic [N-1:0] clr_vec, cond;

   assign clr_vec = wr_stat_i ? wdata_i : '0;
   assign cond    = stat_q & en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q      <= '0;
         en_q        <= '0;
         cond_prev_q <= '0;
      end else begin
         // A strobe beats a clear in the same cycle
         stat_q      <= ((stat_q & ~clr_vec) | set_i) & USED;
         if (wr_en_i)
            en_q     <= wdata_i & USED;
         cond_prev_q <= cond;
      end
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign rise_o = cond & ~cond_prev_q;

endmodule

// File: rtl/hier_irq_top_stage.sv
module hier_irq_top_stage #(
   parameter int NS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NS-1:0] set_i,
   input  logic          wr_stat_i,
   input  logic          wr_en_i,
   input  logic          wr_mask_i,
   input  logic [NS-1:0] wdata_i,
   output logic [NS-1:0] pend_o,
   output logic [NS-1:0] en_o,
   output logic [NS-1:0] mask_o,
   output logic          irq_o
);

   logic [NS-1:0] en_q, mask_q;

   for (genvar k = 0; k < NS; k++) begin : g_src
      logic pend_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend_q <= 1'b0;
         else if (set_i[k])
            pend_q <= 1'b1;
         else if (wr_stat_i && wdata_i[k])
            pend_q <= 1'b0;
      end
      assign pend_o[k] = pend_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         mask_q <= '0;
      end else begin
         if (wr_en_i)
            en_q   <= wdata_i;
         if (wr_mask_i)
            mask_q <= wdata_i;
      end
   end

   assign en_o   = en_q;
   assign mask_o = mask_q;
   assign irq_o  = |(pend_o & en_q & ~mask_q);

endmodule

// File: rtl/hier_irq_agg.sv
module hier_irq_agg
   import hier_irq_pkg::*;
#(
   parameter int                    DATA_W     = 32,
   parameter int                    ADDR_W     = 8,
   parameter int                    NUM_CAUSES = 8,
   parameter logic [NUM_CAUSES-1:0] CAUSE_USED = 8'h07
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CAUSES-1:0] cause_set,
   input  logic                  mbox_evt,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic                  host_irq
);

   localparam int MIN_ADDR_W = $clog2(OFF_TOP_MASK + 1);

   if (NUM_CAUSES < 1 || NUM_CAUSES >= DATA_W) begin : g_bad_causes
      $error("hier_irq_agg: NUM_CAUSES must be in 1..DATA_W-1");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("hier_irq_agg: ADDR_W too narrow for the register map");
   end
   if (CAUSE_USED == '0) begin : g_bad_used
      $error("hier_irq_agg: at least one cause must be implemented");
   end

   reg_sel_t              hit, wsel;
   logic [NUM_CAUSES-1:0] cause_stat, cause_en, cause_rise;
   logic [NUM_SRC-1:0]    top_set, top_pend, top_en_q, top_mask_q;
   logic                  unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_CAUSES];

   hier_irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i (reg_addr),
      .hit_o  (hit)
   );

   assign wsel = reg_wr ? hit : '0;

   hier_irq_cause_bank #(.N(NUM_CAUSES), .USED(CAUSE_USED)) u_cause (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (cause_set),
      .wr_stat_i (wsel.cause_stat),
      .wr_en_i   (wsel.cause_en),
      .wdata_i   (reg_wdata[NUM_CAUSES-1:0]),
      .stat_o    (cause_stat),
      .en_o      (cause_en),
      .rise_o    (cause_rise)
   );

   always_comb begin
      top_set          = '0;
      top_set[SRC_SEC] = |cause_rise;
      top_set[SRC_BRG] = mbox_evt;
   end

   hier_irq_top_stage #(.NS(NUM_SRC)) u_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (top_set),
      .wr_stat_i (wsel.top_stat),
      .wr_en_i   (wsel.top_en),
      .wr_mask_i (wsel.top_mask),
      .wdata_i   (reg_wdata[NUM_SRC-1:0]),
      .pend_o    (top_pend),
      .en_o      (top_en_q),
      .mask_o    (top_mask_q),
      .irq_o     (host_irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (hit.cause_stat) reg_rdata = DATA_W'(cause_stat);
      if (hit.cause_en)   reg_rdata = DATA_W'(cause_en);
      if (hit.top_stat)   reg_rdata = DATA_W'(top_pend);
      if (hit.top_en)     reg_rdata = DATA_W'(top_en_q);
      if (hit.top_mask)   reg_rdata = DATA_W'(top_mask_q);
   end

endmodule

// File: rtl/hier_irq_agg_chk.sv
module hier_irq_agg_chk
   import hier_irq_pkg::*;
#(
   parameter int                    DATA_W     = 32,
   parameter int                    ADDR_W     = 8,
   parameter int                    NUM_CAUSES = 8,
   parameter logic [NUM_CAUSES-1:0] CAUSE_USED = 8'h07
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_CAUSES-1:0] cause_set,
   input logic                  mbox_evt,
   input logic                  reg_wr,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic [DATA_W-1:0]     reg_wdata,
   input logic [NUM_CAUSES-1:0] cause_stat,
   input logic [NUM_CAUSES-1:0] cause_rise,
   input logic [NUM_SRC-1:0]    top_pend,
   input logic [NUM_SRC-1:0]    top_mask_q,
   input logic                  host_irq
);

   logic top_clr_brg;
   assign top_clr_brg = reg_wr && (reg_addr == ADDR_W'(OFF_TOP_STAT)) && reg_wdata[SRC_BRG];

   // R2: strobe on an implemented cause lands in status
   assert_cause_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_set & CAUSE_USED) != '0) |=>
      ((cause_stat & $past(cause_set & CAUSE_USED)) == $past(cause_set & CAUSE_USED)));

   // R5: secure flag rises only after a lower-level condition edge
   assert_sec_needs_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(top_pend[SRC_SEC]) |-> $past(|cause_rise));

   // R7: mailbox strobe sets the bridge flag, even against a clear
   assert_brg_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mbox_evt |=> top_pend[SRC_BRG]);

   // R7: write-one-to-clear of the bridge flag
   assert_brg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (top_clr_brg && !mbox_evt) |=> !top_pend[SRC_BRG]);

   // R9: no pending source, no interrupt
   assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (top_pend == '0) |-> !host_irq);

   // R9: all sources masked, no interrupt
   assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (top_mask_q == '1) |-> !host_irq);

endmodule

bind hier_irq_agg hier_irq_agg_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CAUSES(NUM_CAUSES), .CAUSE_USED(CAUSE_USED)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cause_set  (cause_set),
   .mbox_evt   (mbox_evt),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .cause_stat (cause_stat),
   .cause_rise (cause_rise),
   .top_pend   (top_pend),
   .top_mask_q (top_mask_q),
   .host_irq   (host_irq)
);

// File: tb/hier_irq_agg_bench.sv
module hier_irq_agg_bench;

   localparam int DW = 32;
   localparam int AW = 8;
   localparam int NC = 8;

   localparam logic [AW-1:0] A_CST = 8'h00, A_CEN = 8'h04, A_TST = 8'h08,
                             A_TEN = 8'h0C, A_TMK = 8'h10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] cause_set = '0;
   logic          mbox_evt = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          host_irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;  // 50 MHz

   hier_irq_agg u_hier_irq_agg (
      .clk(clk), .rst_n(rst_n), .cause_set(cause_set), .mbox_evt(mbox_evt),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .host_irq(host_irq)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic reg_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic expect_reg(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      logic [DW-1:0] v;
      reg_read(a, v);
      check(req, v, exp);
   endtask

   task automatic expect_irq(input string req, input logic exp);
      #1 check(req, DW'(host_irq), DW'(exp));
   endtask

   task automatic pulse_cause(input logic [NC-1:0] m);
      @(negedge clk);
      cause_set = m;
      @(negedge clk);
      cause_set = '0;
   endtask

   task automatic pulse_mbox();
      @(negedge clk);
      mbox_evt = 1'b1;
      @(negedge clk);
      mbox_evt = 1'b0;
   endtask

   task automatic cleanup();
      reg_write(A_CEN, 0);
      reg_write(A_CST, 32'hFF);
      reg_write(A_TEN, 0);
      reg_write(A_TMK, 0);
      reg_write(A_TST, 32'h3);
      step(1);
   endtask

   task automatic t_reset();
      step(1);
      expect_reg("R1 cause stat", A_CST, 0);
      expect_reg("R1 cause en", A_CEN, 0);
      expect_reg("R1 top stat", A_TST, 0);
      expect_reg("R1 top en", A_TEN, 0);
      expect_reg("R1 top mask", A_TMK, 0);
      expect_irq("R1 irq", 1'b0);
   endtask

   task automatic t_cause_regs();
      pulse_cause(8'hFF);
      expect_reg("R2 used bits set, reserved ignore strobe", A_CST, 32'h07);
      reg_write(A_CST, 32'h02);
      expect_reg("R3 w1c clears bit1", A_CST, 32'h05);
      reg_write(A_CST, 32'h00);
      expect_reg("R3 write zero no effect", A_CST, 32'h05);
      @(negedge clk);
      cause_set = 8'h01; reg_wr = 1'b1; reg_addr = A_CST; reg_wdata = 32'h01;
      @(negedge clk);
      cause_set = '0; reg_wr = 1'b0; reg_wdata = '0;
      expect_reg("R3 set wins over clear", A_CST, 32'h05);
      reg_write(A_CST, 32'hFF);
      expect_reg("R3 all cleared", A_CST, 0);
      reg_write(A_CEN, 32'hFF);
      expect_reg("R4 enable keeps bits 0..2", A_CEN, 32'h07);
      reg_write(A_CEN, 32'h05);
      expect_reg("R4 enable readback", A_CEN, 32'h05);
      cleanup();
   endtask

   task automatic t_edge();
      reg_write(A_CEN, 32'h02);
      reg_write(A_TEN, 32'h01);
      pulse_cause(8'h02);
      expect_reg("R5 flag not yet", A_TST, 0);
      step(1);
      expect_reg("R5 flag one cycle after condition", A_TST, 32'h1);
      expect_irq("R9 secure irq", 1'b1);
      reg_write(A_TST, 32'h1);
      step(3);
      expect_reg("R5 held condition no re-trigger", A_TST, 0);
      expect_irq("R5 irq stays low", 1'b0);
      pulse_cause(8'h02);
      step(2);
      expect_reg("R5 strobe on set cause no edge", A_TST, 0);
      reg_write(A_CST, 32'h02);
      pulse_cause(8'h02);
      step(1);
      expect_reg("R5 new edge after clear", A_TST, 32'h1);
      reg_write(A_TEN, 0);
      expect_reg("R8 pending shown while disabled", A_TST, 32'h1);
      expect_irq("R9 disabled no irq", 1'b0);
      reg_write(A_TEN, 32'h1);
      reg_write(A_TMK, 32'h1);
      expect_reg("R8 pending shown while masked", A_TST, 32'h1);
      expect_irq("R9 masked no irq", 1'b0);
      reg_write(A_TMK, 0);
      expect_irq("R9 unmasked irq", 1'b1);
      cleanup();
   endtask

   task automatic t_enable_edge();
      pulse_cause(8'h04);
      step(2);
      expect_reg("R6 disabled cause no flag", A_TST, 0);
      reg_write(A_CEN, 32'h04);
      expect_reg("R6 flag not yet", A_TST, 0);
      step(1);
      expect_reg("R6 enabling set cause is an edge", A_TST, 32'h1);
      cleanup();
   endtask

   task automatic t_bridge();
      pulse_mbox();
      expect_reg("R7 mailbox sets bridge flag", A_TST, 32'h2);
      expect_irq("R9 bridge not enabled", 1'b0);
      reg_write(A_TEN, 32'h1);
      expect_irq("R9 wrong source enabled", 1'b0);
      reg_write(A_TEN, 32'h2);
      expect_irq("R9 bridge enabled irq", 1'b1);
      @(negedge clk);
      mbox_evt = 1'b1; reg_wr = 1'b1; reg_addr = A_TST; reg_wdata = 32'h2;
      @(negedge clk);
      mbox_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      expect_reg("R7 strobe wins over clear", A_TST, 32'h2);
      reg_write(A_TST, 32'h2);
      expect_reg("R7 w1c bridge", A_TST, 0);
      expect_irq("R9 irq drops", 1'b0);
      cleanup();
   endtask

   task automatic t_map();
      reg_write(8'h14, 32'hFFFF_FFFF);
      reg_write(8'h20, 32'hFFFF_FFFF);
      expect_reg("R10 unmapped read 0x14", 8'h14, 0);
      expect_reg("R10 unmapped read 0x20", 8'h20, 0);
      expect_reg("R10 cause stat untouched", A_CST, 0);
      expect_reg("R10 cause en untouched", A_CEN, 0);
      expect_reg("R10 top en untouched", A_TEN, 0);
      expect_reg("R10 top mask untouched", A_TMK, 0);
      expect_irq("R10 irq low", 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cause_regs();
      t_edge();
      t_enable_edge();
      t_bridge();
      t_map();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule